// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Error Flags

This block receives asynchronous serial characters on a single input line. A free-running tick at sixteen times the baud rate paces it. It finds the falling edge of a start bit and confirms it at the middle of the bit. It then samples each data bit at its centre, least significant bit first, and converts the bits into a parallel word. An optional parity bit and the stop bit follow. When the stop bit is sampled, the character moves into a receive buffer that the host can read. A one-cycle completion interrupt marks the move.

The host reaches the block through a small register port with separate read and write strobes and a 2-bit address. Reads return data in the same cycle. The mode register selects:
- whether reception is enabled,
- 7- or 8-bit characters,
- one of four parity rules.

The status register collects parity, framing and overrun errors. These flags stay set until the host reads the status register. The baud tick comes from outside the block. The serial input is expected to be already synchronised to the clock.

Top module: `serial_rx_unit`

## Requirements
- R1: Address 0 is the mode register. All 8 bits read back as written. Bit 0 enables reception. Bit 1 selects 7-bit characters. Bits 3:2 select parity: 00 none, 01 even, 10 odd, 11 parity bit must be 0. Bits 7:4 have no function.
- R2: While idle and enabled, a tick that sees the line low begins a start bit. The line is sampled again 8 ticks later; if it is high, the attempt is dropped. Otherwise data bits are sampled every 16 ticks, LSB first. The parity bit follows if parity is enabled, then the stop bit.
- R3: The receive buffer (address 2) is loaded only when the stop bit is sampled, and only if bit 0 of the mode register is 1 in that cycle. Otherwise the buffer, the flags and the interrupt stay unchanged.
- R4: For a 7-bit character, bit 7 of the buffer reads 0 whatever the line carried.
- R5: The interrupt output is high for exactly one cycle, in the cycle after the stop-bit sample edge, once for each buffer load.
- R6: Even rule: the parity bit equals the XOR of the data bits. Odd rule: it equals the inverse of that XOR. Zero rule: it is 0. A mismatch sets status bit 0.
- R7: A stop bit sampled as 0 sets status bit 1, and the character is still stored.
- R8: A load while the previous character has not been read at address 2 sets status bit 2 and replaces the buffer.
- R9: Status flags are sticky. A read of address 1 clears them at that clock edge, except a flag that is set in the same cycle, which stays 1.
- R10: Reset clears the mode register, the buffer, the flags and the interrupt. Address 3 reads 0.
- R11: Character length and parity rule are captured at the start bit, so a mode change during a frame applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse at 16 times the baud rate |
| rxd_i | input | 1 | Serial line, idle high, already synchronised |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives read-clear side effects) |
| reg_addr_i | input | 2 | Register address: 0 mode, 1 status, 2 data |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register, combinational |
| rx_irq_o | output | 1 | Receive-complete pulse |

## Verification
The hardest situation to reach from the ports is a status read that falls in the same clock cycle as a character load raising a new error. The host cannot see that cycle in advance. To reach it, the bench holds the status read strobe asserted for a whole frame that has a bad stop bit. It drops the strobe on the clock after the interrupt appears, then reads the status once more to see whether the flag survived. A behavioural model that counts ticks from the start edge follows every cycle, so buffer, flag and interrupt timing are compared continuously.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP
  } rx_state_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int MB_EN  = 0;
  localparam int MB_C7  = 1;
  localparam int MB_PM0 = 2;

  localparam int ST_PAR = 0;
  localparam int ST_FRM = 1;
  localparam int ST_OVR = 2;
  localparam int ST_N   = 3;

  // data_xor is the XOR of the received data bits
  function automatic logic parity_ok(par_mode_e pm, logic data_xor, logic pbit);
    logic ok;
    unique case (pm)
      PAR_EVEN: ok = (pbit == data_xor);
      PAR_ODD:  ok = (pbit != data_xor);
      PAR_ZERO: ok = !pbit;
      default:  ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         rxd_i,
  input  logic         en_i,
  input  logic         char7_i,
  input  par_mode_e    pmode_i,
  output logic         done_o,
  output logic [W-1:0] word_o,
  output logic         perr_o,
  output logic         ferr_o,
  output logic         char7_o
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(W);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST8 = BW'(W - 1);
  localparam logic [BW-1:0] LAST7 = BW'(W - 2);

  rx_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bidx_q;
  logic [W-1:0]  sh_q;
  logic          c7_q;
  par_mode_e     pm_q;
  logic          pbit_q;

  logic slot_end;
  logic half_end;
  logic last_bit;
  logic data_xor;

  assign slot_end = tick_i && (cnt_q == FULL_LAST);
  assign half_end = tick_i && (cnt_q == HALF_LAST);
  assign last_bit = (bidx_q == (c7_q ? LAST7 : LAST8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      c7_q   <= 1'b0;
      pm_q   <= PAR_NONE;
      pbit_q <= 1'b0;
    end else if (tick_i) begin
      unique case (st_q)
        RS_IDLE: begin
          if (en_i && !rxd_i) begin
            st_q  <= RS_START;
            cnt_q <= '0;
            sh_q  <= '0;
            c7_q  <= char7_i;
            pm_q  <= pmode_i;
          end
        end
        RS_START: begin
          if (half_end) begin
            cnt_q  <= '0;
            bidx_q <= '0;
            st_q   <= rxd_i ? RS_IDLE : RS_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RS_DATA: begin
          if (slot_end) begin
            cnt_q        <= '0;
            sh_q[bidx_q] <= rxd_i;
            if (last_bit) st_q <= (pm_q == PAR_NONE) ? RS_STOP : RS_PAR;
            else          bidx_q <= bidx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RS_PAR: begin
          if (slot_end) begin
            cnt_q  <= '0;
            pbit_q <= rxd_i;
            st_q   <= RS_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RS_STOP: begin
          if (slot_end) begin
            cnt_q <= '0;
            st_q  <= RS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  assign word_o   = c7_q ? {1'b0, sh_q[W-2:0]} : sh_q;
  assign data_xor = ^word_o;
  assign done_o   = slot_end && (st_q == RS_STOP);
  assign perr_o   = !parity_ok(pm_q, data_xor, pbit_q);
  assign ferr_o   = !rxd_i;
  assign char7_o  = c7_q;

endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [1:0]      addr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            done_i,
  input  logic [W-1:0]    word_i,
  input  logic            perr_i,
  input  logic            ferr_i,
  output logic [W-1:0]    rdata_o,
  output logic            irq_o,
  output logic            en_o,
  output logic            char7_o,
  output par_mode_e       pmode_o,
  output logic [W-1:0]    buf_o,
  output logic            full_o,
  output logic [ST_N-1:0] stat_o,
  output logic            commit_o,
  output logic            stat_rd_o,
  output logic            data_rd_o
);

  logic [W-1:0]    mode_q;
  logic [W-1:0]    buf_q;
  logic            full_q;
  logic [ST_N-1:0] stat_q;
  logic            irq_q;
  logic [ST_N-1:0] new_flags;

  assign en_o      = mode_q[MB_EN];
  assign char7_o   = mode_q[MB_C7];
  assign pmode_o   = par_mode_e'(mode_q[MB_PM0+1:MB_PM0]);
  assign commit_o  = done_i && en_o;
  assign stat_rd_o = rd_i && (addr_i == ADDR_STAT);
  assign data_rd_o = rd_i && (addr_i == ADDR_DATA);

  always_comb begin
    new_flags         = '0;
    new_flags[ST_PAR] = commit_o && perr_i;
    new_flags[ST_FRM] = commit_o && ferr_i;
    new_flags[ST_OVR] = commit_o && full_q && !data_rd_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= commit_o;
      stat_q <= (stat_rd_o ? '0 : stat_q) | new_flags;
      if (commit_o) begin
        buf_q  <= word_i;
        full_q <= 1'b1;
      end else if (data_rd_o) begin
        full_q <= 1'b0;
      end
      if (wr_i && (addr_i == ADDR_MODE)) mode_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MODE: rdata_o = mode_q;
      ADDR_STAT: rdata_o[ST_N-1:0] = stat_q;
      ADDR_DATA: rdata_o = buf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o  = irq_q;
  assign buf_o  = buf_q;
  assign full_o = full_q;
  assign stat_o = stat_q;

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16_i,
  input  logic         rxd_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         rx_irq_o
);

  logic            frame_done;
  logic [W-1:0]    frame_word;
  logic            frame_perr;
  logic            frame_ferr;
  logic            frame_char7;
  logic            mode_en;
  logic            mode_char7;
  par_mode_e       mode_pm;
  logic [W-1:0]    buf_q;
  logic            buf_full;
  logic [ST_N-1:0] stat_q;
  logic            commit_evt;
  logic            stat_rd;
  logic            data_rd;

  srx_sampler #(.W(W), .OVS(OVS)) u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick16_i),
    .rxd_i   (rxd_i),
    .en_i    (mode_en),
    .char7_i (mode_char7),
    .pmode_i (mode_pm),
    .done_o  (frame_done),
    .word_o  (frame_word),
    .perr_o  (frame_perr),
    .ferr_o  (frame_ferr),
    .char7_o (frame_char7)
  );

  srx_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (frame_done),
    .word_i    (frame_word),
    .perr_i    (frame_perr),
    .ferr_i    (frame_ferr),
    .rdata_o   (reg_rdata_o),
    .irq_o     (rx_irq_o),
    .en_o      (mode_en),
    .char7_o   (mode_char7),
    .pmode_o   (mode_pm),
    .buf_o     (buf_q),
    .full_o    (buf_full),
    .stat_o    (stat_q),
    .commit_o  (commit_evt),
    .stat_rd_o (stat_rd),
    .data_rd_o (data_rd)
  );

endmodule

// File: rtl/srx_checker.sv
module srx_checker
  import srx_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rxd,
  input logic            rx_irq,
  input logic            frame_done,
  input logic            frame_char7,
  input logic            mode_en,
  input logic            commit_evt,
  input logic            buf_full,
  input logic [W-1:0]    buf_q,
  input logic [ST_N-1:0] stat_q,
  input logic            stat_rd,
  input logic            data_rd
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R5

  AST_IRQ_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> buf_full); // R5

  AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !mode_en) |=> !rx_irq); // R3

  AST_SHORT_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && frame_char7) |=> !buf_q[W-1]); // R4

  AST_FRAMING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !rxd) |=> stat_q[ST_FRM]); // R7

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && buf_full && !data_rd) |=> stat_q[ST_OVR]); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9

endmodule

bind serial_rx_unit srx_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rxd         (rxd_i),
  .rx_irq      (rx_irq_o),
  .frame_done  (frame_done),
  .frame_char7 (frame_char7),
  .mode_en     (mode_en),
  .commit_evt  (commit_evt),
  .buf_full    (buf_full),
  .buf_q       (buf_q),
  .stat_q      (stat_q),
  .stat_rd     (stat_rd),
  .data_rd     (data_rd)
);

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_irq;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  bit live = 1'b0;
  int tdiv = 0;

  always #5 clk = ~clk;

  serial_rx_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16_i    (tick16),
    .rxd_i       (rxd),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .rx_irq_o    (rx_irq)
  );

  // tick every 4 clocks, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv   = 0;
      tick16 = 1'b0;
    end else begin
      tdiv   = (tdiv + 1) % 4;
      tick16 = (tdiv == 0);
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mode, m_buf, m_word;
  logic [2:0] m_stat;
  logic       m_full, m_irq, m_pbit;
  int         m_tk, m_n, m_pm;

  function automatic logic [7:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return {5'b0, m_stat};
      2'd2: return m_buf;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_buf = 0; m_stat = 0; m_full = 0; m_irq = 0;
      m_tk = -1; m_n = 8; m_pm = 0; m_word = 0; m_pbit = 0;
    end else begin
      bit         cmt;
      logic [2:0] nf;
      logic [7:0] cword;
      int         ones, k;
      cmt = 0; nf = 0; cword = 0;
      if (tick16) begin
        if (m_tk < 0) begin
          if (m_mode[0] && !rxd) begin
            m_tk = 0; m_word = 0;
            m_n = m_mode[1] ? 7 : 8;
            m_pm = int'(m_mode[3:2]);
          end
        end else begin
          m_tk++;
          if (m_tk == 8) begin
            if (rxd) m_tk = -1;
          end else if (m_tk > 8 && ((m_tk - 8) % 16) == 0) begin
            k = (m_tk - 8) / 16;
            if (k <= m_n) m_word[k-1] = rxd;
            else if (m_pm != 0 && k == m_n + 1) m_pbit = rxd;
            else begin
              if (m_mode[0]) begin
                cmt = 1; cword = m_word;
                ones = 0;
                for (int i = 0; i < m_n; i++) ones += int'(m_word[i]);
                case (m_pm)
                  1: nf[0] = (m_pbit != ones[0]);
                  2: nf[0] = (m_pbit == ones[0]);
                  3: nf[0] = m_pbit;
                  default: nf[0] = 0;
                endcase
                nf[1] = !rxd;
              end
              m_tk = -1;
            end
          end
        end
      end
      m_irq = cmt;
      if (cmt && m_full && !(reg_rd && reg_addr == 2'd2)) nf[2] = 1;
      if (reg_rd && reg_addr == 2'd1) m_stat = 0;
      m_stat = m_stat | nf;
      if (cmt) begin m_buf = cword; m_full = 1; end
      else if (reg_rd && reg_addr == 2'd2) m_full = 0;
      if (reg_wr && reg_addr == 2'd0) m_mode = reg_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && live) begin
      chk("R5 irq", {31'b0, rx_irq}, {31'b0, m_irq});
      case (reg_addr)
        2'd0: chk("R1 rdata", {24'b0, reg_rdata}, {24'b0, m_rdata(reg_addr)});
        2'd1: chk("R9 rdata", {24'b0, reg_rdata}, {24'b0, m_rdata(reg_addr)});
        2'd2: chk("R3 rdata", {24'b0, reg_rdata}, {24'b0, m_rdata(reg_addr)});
        default: chk("R10 rdata", {24'b0, reg_rdata}, {24'b0, m_rdata(reg_addr)});
      endcase
    end
  end

  always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] data, input int nbits, input int pm,
                            input bit flip, input logic stopv);
    logic p;
    p = 1'b0;
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < nbits; i++) begin
      hold_bit(data[i]);
      p = p ^ data[i];
    end
    if (pm != 0) begin
      if (pm == 2) p = ~p;
      else if (pm == 3) p = 1'b0;
      hold_bit(p ^ flip);
    end
    hold_bit(stopv);
    hold_bit(1'b1);
  endtask

  task automatic expect_regs(input string req, input logic [7:0] exp_data,
                             input logic [7:0] exp_stat);
    logic [7:0] v;
    rd(2'd2, v); chk({req, " data"}, {24'b0, v}, {24'b0, exp_data});
    rd(2'd1, v); chk({req, " status"}, {24'b0, v}, {24'b0, exp_stat});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;

    // R10: reset values
    rd(2'd0, v); chk("R10 mode reset", {24'b0, v}, 32'h00);
    rd(2'd1, v); chk("R10 status reset", {24'b0, v}, 32'h00);
    rd(2'd2, v); chk("R10 data reset", {24'b0, v}, 32'h00);
    rd(2'd3, v); chk("R10 addr3", {24'b0, v}, 32'h00);
    chk("R10 irq reset", {31'b0, rx_irq}, 32'h0);

    // R1: full read-back of the mode register
    wr(2'd0, 8'hF0); rd(2'd0, v); chk("R1 mode readback", {24'b0, v}, 32'hF0);
    wr(2'd0, 8'h01);

    // R2 R3 R5: plain 8-bit frame, no parity
    base = irq_cnt;
    send_frame(8'hA5, 8, 0, 0, 1'b1);
    chk("R5 one pulse", irq_cnt - base, 1);
    expect_regs("R2", 8'hA5, 8'h00);

    // R2: short low glitch is not a start bit
    base = irq_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk("R2 glitch no load", irq_cnt - base, 0);
    rd(2'd1, v); chk("R2 glitch status", {24'b0, v}, 32'h00);

    // R6: 7-bit even parity, correct and wrong
    wr(2'd0, 8'h07);
    send_frame(8'h5A, 7, 1, 0, 1'b1);
    expect_regs("R6 even ok", 8'h5A, 8'h00);
    send_frame(8'h5A, 7, 1, 1, 1'b1);
    expect_regs("R6 even bad", 8'h5A, 8'h01);
    rd(2'd1, v); chk("R9 cleared by read", {24'b0, v}, 32'h00);

    // R6: odd and zero rules on 8-bit characters
    wr(2'd0, 8'h09);
    send_frame(8'h03, 8, 2, 0, 1'b1);
    expect_regs("R6 odd ok", 8'h03, 8'h00);
    wr(2'd0, 8'h0D);
    send_frame(8'h81, 8, 3, 1, 1'b1);
    expect_regs("R6 zero bad", 8'h81, 8'h01);

    // R4: 7-bit no parity, line carries a 1 after the seventh bit
    wr(2'd0, 8'h03);
    send_frame(8'hFF, 8, 0, 0, 1'b1);
    expect_regs("R4 msb zero", 8'h7F, 8'h00);

    // R7: bad stop bit still stores the character
    wr(2'd0, 8'h01);
    send_frame(8'h3C, 8, 0, 0, 1'b0);
    expect_regs("R7 framing", 8'h3C, 8'h02);

    // R8: two characters without reading data
    send_frame(8'h11, 8, 0, 0, 1'b1);
    send_frame(8'h22, 8, 0, 0, 1'b1);
    expect_regs("R8 overrun", 8'h22, 8'h04);
    rd(2'd1, v); chk("R8 overrun cleared", {24'b0, v}, 32'h00);

    // R9: status read held across the load cycle; new flag survives
    @(negedge clk); reg_addr = 2'd1; reg_rd = 1'b1;
    fork
      send_frame(8'h44, 8, 0, 0, 1'b0);
      begin
        do @(negedge clk); while (!rx_irq);
        reg_rd = 1'b0;
      end
    join
    expect_regs("R9 same-cycle set", 8'h44, 8'h02);

    // R3: reception disabled for the whole frame
    wr(2'd0, 8'h00);
    base = irq_cnt;
    send_frame(8'h99, 8, 0, 0, 1'b1);
    chk("R3 disabled no irq", irq_cnt - base, 0);
    expect_regs("R3 disabled", 8'h44, 8'h00);

    // R3: disabled during the frame, before the stop bit
    wr(2'd0, 8'h01);
    base = irq_cnt;
    fork
      send_frame(8'h66, 8, 0, 0, 1'b1);
      begin repeat (300) @(negedge clk); wr(2'd0, 8'h00); end
    join
    chk("R3 mid disable no irq", irq_cnt - base, 0);
    expect_regs("R3 mid disable", 8'h44, 8'h00);

    // R11: switch to 7-bit mid-frame; frame keeps 8-bit length
    wr(2'd0, 8'h01);
    base = irq_cnt;
    fork
      send_frame(8'hC3, 8, 0, 0, 1'b1);
      begin repeat (300) @(negedge clk); wr(2'd0, 8'h03); end
    join
    chk("R11 latched irq", irq_cnt - base, 1);
    expect_regs("R11 latched cfg", 8'hC3, 8'h00);

    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule